// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers interrupt causes for a network controller and turns them into a single level-sensitive interrupt line. It keeps a 32-bit cause register and a 32-bit mask register. Internal event pulses and software writes to a dedicated raise address set cause bits. Software removes cause bits either by writing ones to the cause address or by reading that address, which returns the value and then empties the register. Mask bits are set and cleared through two separate addresses, so no read-modify-write is needed.

Whenever the cause register ends up nonzero after an update, its top bit (the summary bit) is forced to one. The line is driven by a two-state machine. In `LINE_QUIET` the output is low. In `LINE_RAISED` it is high. On each clock edge the machine takes transition `RAISE` or `HOLD_RAISED` when the next cause ANDed with the next mask is nonzero, and `DROP` or `HOLD_QUIET` when it is zero. Reset forces `LINE_QUIET`.

Top module: `irqc_top`

## Requirements
- R1: A synchronous active-low reset clears the cause and mask registers and holds the interrupt line low. After reset every read returns zero.
- R2: One clock edge after any update, `irq_o` is high exactly when the cause register ANDed with the mask register is nonzero.
- R3: Each bit set on `event_in` during a cycle is ORed into the cause register at the next edge.
- R4: A write to the raise address (word offset 1) ORs `wdata` into the cause register.
- R5: Whenever the cause register holds a nonzero value after an update, bit 31 (the summary bit) reads as one.
- R6: A read of the cause address (word offset 0) returns the current cause value in the same cycle. At the next edge the register is cleared to zero, which drops the line.
- R7: A write to the cause address clears exactly the cause bits that are one in `wdata`. The summary bit is forced back on if any bit is left.
- R8: A write to the mask-set address (word offset 2) ORs `wdata` into the mask. A read of that address returns the mask.
- R9: A write to the mask-clear address (word offset 3) clears the mask bits that are one in `wdata`. A read of that address returns zero.
- R10: When an event bit and a software clear of the same cause (by read or by write) fall in the same cycle, the event wins and the bit is set after the edge.
- R11: A read of the raise address or of any unmapped offset returns zero. A write to an unmapped offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of `rd_en` |
| event_in | input | 32 | Internal event pulses, one bit per cause |
| irq_o | output | 1 | Level-sensitive interrupt line |

## Verification
Two functions can land on the same edge: an internal event raising a cause, and a software clear of the cause register, either by a read or by a write of ones. The bench provokes both cases on purpose. It pulses `event_in` in the same cycle as a clearing read, and again on the very bit that a clearing write targets. It then judges the outcome through later reads of the cause address. The clearing read must still return the old value, and the event bit must survive the edge together with the summary bit.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned REG_AW = 4;

    // word offsets; the bench and the requirements depend on these
    localparam int unsigned OFS_CAUSE     = 0;
    localparam int unsigned OFS_CAUSE_SET = 1;
    localparam int unsigned OFS_MASK_SET  = 2;
    localparam int unsigned OFS_MASK_CLR  = 3;

    typedef struct packed {
        logic cause_rd;
        logic cause_wr;
        logic cause_set;
        logic mask_rd;
        logic mask_set;
        logic mask_clr;
    } strobe_t;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W = REG_AW
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output strobe_t           stb
);

    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
    localparam logic [ADDR_W-1:0] A_RAISE = ADDR_W'(OFS_CAUSE_SET);
    localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'(OFS_MASK_SET);
    localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'(OFS_MASK_CLR);

    always_comb begin
        stb           = '0;
        stb.cause_rd  = rd_en && (addr == A_CAUSE);
        stb.cause_wr  = wr_en && (addr == A_CAUSE);
        stb.cause_set = wr_en && (addr == A_RAISE);
        stb.mask_rd   = rd_en && (addr == A_MSET);
        stb.mask_set  = wr_en && (addr == A_MSET);
        stb.mask_clr  = wr_en && (addr == A_MCLR);
    end

endmodule

// File: rtl/irqc_cause_reg.sv
module irqc_cause_reg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_by_read,
    input  logic              clr_by_write,
    input  logic              raise_by_write,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] event_in,
    output logic [DATA_W-1:0] cause_q,
    output logic [DATA_W-1:0] cause_d
);

    localparam int unsigned SUM_BIT = DATA_W - 1;

    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] raise_vec;

    always_comb begin
        if (clr_by_write)
            clr_vec = wdata;
        else if (clr_by_read)
            clr_vec = '1;
        else
            clr_vec = '0;
        raise_vec = event_in | (raise_by_write ? wdata : '0);
        // raising is applied after clearing, so an event survives a clear
        cause_d = (cause_q & ~clr_vec) | raise_vec;
        if (cause_d != '0)
            cause_d[SUM_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_q <= '0;
        else
            cause_q <= cause_d;
    end

endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] mask_d
);

    always_comb begin
        mask_d = mask_q;
        if (set_en)
            mask_d = mask_d | wdata;
        if (clr_en)
            mask_d = mask_d & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else
            mask_q <= mask_d;
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = REG_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] event_in,
    output logic              irq_o
);

    strobe_t           stb;
    logic [DATA_W-1:0] cause_q;
    logic [DATA_W-1:0] cause_d;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] mask_d;
    line_state_e       line_q;
    line_state_e       line_d;

    irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .stb   (stb)
    );

    irqc_cause_reg #(.DATA_W(DATA_W)) u_cause (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr_by_read    (stb.cause_rd),
        .clr_by_write   (stb.cause_wr),
        .raise_by_write (stb.cause_set),
        .wdata          (wdata),
        .event_in       (event_in),
        .cause_q        (cause_q),
        .cause_d        (cause_d)
    );

    irqc_mask_reg #(.DATA_W(DATA_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (stb.mask_set),
        .clr_en (stb.mask_clr),
        .wdata  (wdata),
        .mask_q (mask_q),
        .mask_d (mask_d)
    );

    // next-state: RAISE / HOLD_RAISED vs DROP / HOLD_QUIET
    always_comb begin
        line_d = ((cause_d & mask_d) != '0) ? LINE_RAISED : LINE_QUIET;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            line_q <= LINE_QUIET;
        else
            line_q <= line_d;
    end

    always_comb begin
        unique case (line_q)
            LINE_QUIET:  irq_o = 1'b0;
            LINE_RAISED: irq_o = 1'b1;
            default:     irq_o = 1'b0;
        endcase
    end

    always_comb begin
        rdata = '0;
        if (stb.cause_rd)
            rdata = cause_q;
        else if (stb.mask_rd)
            rdata = mask_q;
    end

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = REG_AW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] event_in,
    input logic [DATA_W-1:0] cause_q,
    input logic [DATA_W-1:0] mask_q,
    input logic              irq_o
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (cause_q == '0 && mask_q == '0 && !irq_o));

    // R2
    line_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == ((cause_q & mask_q) != '0));

    // R3
    event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (event_in != '0) |=> ((cause_q & $past(event_in)) == $past(event_in)));

    // R5
    summary_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q != '0) |-> cause_q[DATA_W-1]);

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == ADDR_W'(OFS_CAUSE) && event_in == '0) |=> (cause_q == '0));

    // R8
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_MASK_SET)) |=> ((mask_q & $past(wdata)) == $past(wdata)));

    // R9
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_MASK_CLR)) |=> ((mask_q & $past(wdata)) == '0));

endmodule

bind irqc_top irqc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .event_in (event_in),
    .cause_q  (cause_q),
    .mask_q   (mask_q),
    .irq_o    (irq_o)
);

// File: tb/sim_irqc_top.sv
`timescale 1ns/100ps
module sim_irqc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] event_in = '0;
    logic [31:0] rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] mc = '0;   // expected cause
    logic [31:0] mm = '0;   // expected mask

    localparam logic [3:0] A_CAUSE = 4'd0;
    localparam logic [3:0] A_RAISE = 4'd1;
    localparam logic [3:0] A_MSET  = 4'd2;
    localparam logic [3:0] A_MCLR  = 4'd3;
    localparam logic [31:0] SUM    = 32'h8000_0000;

    always #2.5 clk = ~clk;

    irqc_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .event_in (event_in),
        .irq_o    (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic op(input logic w, input logic r, input logic [3:0] a,
                      input logic [31:0] d, input logic [31:0] e, input string tag);
        logic [31:0] exp_rd;
        logic [31:0] clr;
        logic [31:0] nc;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; event_in = e;
        #1;
        exp_rd = 32'h0;
        if (r && a == A_CAUSE) exp_rd = mc;
        if (r && a == A_MSET)  exp_rd = mm;
        if (r) check(tag, rdata, exp_rd);
        clr = (w && a == A_CAUSE) ? d : ((r && a == A_CAUSE) ? 32'hFFFF_FFFF : 32'h0);
        nc = (mc & ~clr) | e | ((w && a == A_RAISE) ? d : 32'h0);
        if (nc != 0) nc = nc | SUM;
        mc = nc;
        if (w && a == A_MSET) mm = mm | d;
        if (w && a == A_MCLR) mm = mm & ~d;
        @(posedge clk);
        #1;
        wr_en = 0; rd_en = 0; addr = '0; wdata = '0; event_in = '0;
        // R2: line follows cause AND mask one edge after the update
        check("R2", {31'b0, irq_o}, {31'b0, ((mc & mm) != 0)});
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        op(0, 1, A_CAUSE, 0, 0, "R1");
        op(0, 1, A_MSET,  0, 0, "R1");

        // single events, read-to-clear
        for (int i = 0; i < 31; i++) begin
            op(0, 0, A_CAUSE, 0, 32'h1 << i, "R3");
            op(0, 1, A_CAUSE, 0, 0, "R5");
            op(0, 1, A_CAUSE, 0, 0, "R6");
        end

        // software raise
        for (int i = 0; i < 31; i++) begin
            op(1, 0, A_RAISE, 32'h1 << i, 0, "R4");
            op(0, 1, A_CAUSE, 0, 0, "R4");
        end
        op(1, 0, A_RAISE, 32'h0000_0F0F, 32'h0001_0000, "R4");
        op(0, 1, A_CAUSE, 0, 0, "R4");

        // mask set sweep
        for (int i = 0; i < 32; i++) begin
            op(1, 0, A_MSET, 32'h1 << i, 0, "R8");
            op(0, 1, A_MSET, 0, 0, "R8");
        end
        op(1, 0, A_MCLR, 32'h0000_FFFF, 0, "R9");
        op(0, 1, A_MCLR, 0, 0, "R9");
        op(0, 1, A_MSET, 0, 0, "R9");

        // line behaviour per bit
        op(1, 0, A_MCLR, 32'hFFFF_FFFF, 0, "R9");
        for (int i = 0; i < 31; i++) begin
            op(1, 0, A_MSET, 32'h1 << i, 0, "R8");
            op(0, 0, A_CAUSE, 0, 32'h1 << i, "R2");
            op(1, 0, A_CAUSE, 32'h1 << i, 0, "R7");
            op(0, 1, A_CAUSE, 0, 0, "R7");
            op(1, 0, A_MCLR, 32'h1 << i, 0, "R9");
        end

        // partial write-clear
        op(0, 0, A_CAUSE, 0, 32'h0000_00FF, "R3");
        op(1, 0, A_CAUSE, 32'h0000_000F, 0, "R7");
        op(0, 1, A_CAUSE, 0, 0, "R7");

        // summary bit through the mask
        op(1, 0, A_MSET, SUM, 0, "R8");
        op(0, 0, A_CAUSE, 0, 32'h0000_0004, "R5");
        op(0, 1, A_CAUSE, 0, 0, "R5");
        op(1, 0, A_MCLR, SUM, 0, "R9");

        // collisions: event against read-clear and write-clear
        op(0, 0, A_CAUSE, 0, 32'h0000_0008, "R10");
        op(0, 1, A_CAUSE, 0, 32'h0000_0200, "R10");
        op(0, 1, A_CAUSE, 0, 0, "R10");
        op(0, 0, A_CAUSE, 0, 32'h0000_0010, "R10");
        op(1, 0, A_CAUSE, 32'h0000_0010, 32'h0000_0010, "R10");
        op(0, 1, A_CAUSE, 0, 0, "R10");

        // unmapped and write-only offsets
        op(0, 0, A_CAUSE, 0, 32'h0000_0040, "R11");
        op(1, 0, A_MSET, 32'h0000_0040, 0, "R11");
        for (int a = 4; a < 16; a++) begin
            op(1, 0, 4'(a), 32'hFFFF_FFFF, 0, "R11");
            op(0, 1, 4'(a), 0, 0, "R11");
        end
        op(0, 1, A_RAISE, 0, 0, "R11");
        op(0, 1, A_MSET, 0, 0, "R11");
        op(0, 1, A_CAUSE, 0, 0, "R11");

        // reset in the middle of activity
        op(1, 0, A_MSET, 32'h0000_0001, 32'h0000_0001, "R1");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        mc = '0; mm = '0;
        op(0, 1, A_CAUSE, 0, 0, "R1");
        op(0, 1, A_MSET, 0, 0, "R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule